// File: doc/BRIEF.md
# Permissioned Set-Associative Tag Directory

This block is the tag and state store of a cache controller. For each way of each set it keeps the stored line address, a two-bit access permission and an optional lock-owner context. A controller sends it one command at a time, and the block answers each command one cycle later. The answer can be a hit indication, a way number, a grant bit or a victim address.

An access is granted only when the line's permission allows the kind of access requested. A tag whose permission is NotPresent counts as absent, except in a raw lookup mode that ignores permission. Every way of every set also has a true-LRU recency rank. The block uses these ranks to pick the victim to evict from a full set.

Allocation fills the lowest free way, leaves the line Invalid and clears its lock owner. It moves the line to most recently used only when the request asks for it. A command that cannot be carried out sets a sticky error flag and leaves all stored state unchanged.

Top module: `tag_dir`

## Requirements
- R1: The set is selected by the address bits `[IDX_LSB +: log2(SETS)]`. Addresses that differ only above that field compete for the ways of the same set, and other sets are not affected.
- R2: Access (cmd 0) hits only on a valid way whose tag equals the address and whose permission is not NotPresent. Permission codes are 0 NotPresent, 1 Invalid, 2 Read_Only and 3 Read_Write. Kind codes are 0 load, 1 fetch and 2 store. The access is granted on a Read_Write line, and on a Read_Only line for kinds other than store. It is never granted on an Invalid line.
- R3: Any access hit makes that way the most recently used in its set, whether or not the access is granted.
- R4: Raw lookup (cmd 1) reports a tag match on any valid way regardless of permission, together with the lowest matching way. It does not change recency.
- R5: Availability (cmd 2) grants when the set holds the address or has a way that is empty or NotPresent.
- R6: Allocate (cmd 3) fills the lowest empty or NotPresent way and reports that way. It stores the tag with permission Invalid and no lock owner. It makes the way most recently used only when `req_touch` is 1.
- R7: Allocating an address that is already present, allocating into a set with no free way, or issuing any undefined command (10 to 15) sets `err` and changes nothing.
- R8: Deallocate (cmd 4) empties the present matching way. Deallocating an absent address sets `err`.
- R9: Probe (cmd 5) on a set that is not available for the address returns the address and way of the least recently used way, with grant 1. On an available set it returns grant 0 and address 0, and it sets `err`.
- R10: Lock-set (cmd 6) stores `req_ctx` as owner and lock-clear (cmd 7) removes the owner. Lock-test (cmd 8) grants only when the owner equals `req_ctx`. All three set `err` when the line is not present.
- R11: Set-permission (cmd 9) writes `req_perm` into the lowest valid way whose tag matches, ignoring its present permission. It sets `err` when no tag matches.
- R12: `req_ready` is always 1. `resp_valid` is 1 exactly in the cycle after an accepted request. After reset, all ways are empty, `err` is 0, and within every set way i has recency rank i, so the highest way is the first victim.
- R13: Once set, `err` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Always 1 |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_kind | input | 2 | Access kind for cmd 0 |
| req_perm | input | 2 | Permission for cmd 9 |
| req_ctx | input | CTX_W | Lock context |
| req_touch | input | 1 | Allocate marks the line most recently used |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Lookup result for the command |
| resp_way | output | log2(WAYS) | Matched, filled or victim way |
| resp_grant | output | 1 | Command-specific success or grant |
| resp_addr | output | ADDR_W | Victim line address (probe only) |
| err | output | 1 | Sticky misuse flag |

## Verification
The properties assume that `req_addr` is line-aligned. They also assume that `req_kind` never takes the unused code 3, because the grant rule does not define it. The stimulus draws addresses from a few tags in two sets and clears the low offset bits, which keeps both assumptions true. Because `err` never clears by itself, the bench resets the block after each error case, and every few hundred random commands, so that later errors can still be seen. The reference model tracks recency as an ordered list per set and checks every response field on every clock.

// File: rtl/tag_dir.sv
module tag_dir #(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 6,
  parameter int SETS    = 8,
  parameter int WAYS    = 4,
  parameter int CTX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_perm,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_touch,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [$clog2(WAYS)-1:0] resp_way,
  output logic              resp_grant,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              err
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [1:0] P_NP = 2'd0, P_INV = 2'd1, P_RO = 2'd2, P_RW = 2'd3;

  logic [ADDR_W-1:0] tag_q  [SETS][WAYS];
  logic              vld_q  [SETS][WAYS];
  logic [1:0]        perm_q [SETS][WAYS];
  logic              lkv_q  [SETS][WAYS];
  logic [CTX_W-1:0]  own_q  [SETS][WAYS];
  logic [WAY_W-1:0]  rank_q [SETS][WAYS];

  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
    lowest = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (v[i]) lowest = i[WAY_W-1:0];
  endfunction

  logic [SET_W-1:0] set_i;
  logic [WAYS-1:0]  tm, pm, fr, lr;
  assign set_i = req_addr[IDX_LSB +: SET_W];
  assign req_ready = 1'b1;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tm[w] = vld_q[set_i][w] && (tag_q[set_i][w] == req_addr);
      pm[w] = tm[w] && (perm_q[set_i][w] != P_NP);
      fr[w] = !vld_q[set_i][w] || (perm_q[set_i][w] == P_NP);
      lr[w] = (rank_q[set_i][w] == WAY_W'(WAYS - 1));
    end
  end

  logic present, any, free, avail;
  logic [WAY_W-1:0] pway, away, fway, vway, wsel;
  assign present = |pm;
  assign any     = |tm;
  assign free    = |fr;
  assign avail   = any || free;
  assign pway    = lowest(pm);
  assign away    = lowest(tm);
  assign fway    = lowest(fr);
  assign vway    = lowest(lr);

  always_comb begin
    case (req_cmd)
      4'd1, 4'd9: wsel = away;
      4'd3:       wsel = fway;
      4'd5:       wsel = vway;
      default:    wsel = pway;
    endcase
  end

  logic [ADDR_W-1:0] cur_tag;
  logic [1:0]        cur_perm;
  logic              cur_lkv;
  logic [CTX_W-1:0]  cur_own;
  assign cur_tag  = tag_q[set_i][wsel];
  assign cur_perm = perm_q[set_i][wsel];
  assign cur_lkv  = lkv_q[set_i][wsel];
  assign cur_own  = own_q[set_i][wsel];

  logic o_hit, o_grant, o_err, wr_en, n_vld, n_lkv, t_en;
  logic [WAY_W-1:0]  o_way, t_way;
  logic [ADDR_W-1:0] o_addr, n_tag;
  logic [1:0]        n_perm;
  logic [CTX_W-1:0]  n_own;

  always_comb begin
    o_hit = present; o_way = pway; o_grant = 1'b0; o_err = 1'b0; o_addr = '0;
    wr_en = 1'b0; n_vld = 1'b1; n_tag = cur_tag; n_perm = cur_perm;
    n_lkv = cur_lkv; n_own = cur_own; t_en = 1'b0; t_way = pway;
    case (req_cmd)
      4'd0: begin
        o_grant = present && (cur_perm == P_RW || (cur_perm == P_RO && req_kind != 2'd2));
        t_en = present;
      end
      4'd1: begin o_hit = any; o_way = away; end
      4'd2: o_grant = avail;
      4'd3: begin
        o_way = fway;
        if (present || !free) o_err = 1'b1;
        else begin
          o_grant = 1'b1; wr_en = 1'b1; n_tag = req_addr; n_perm = P_INV;
          n_lkv = 1'b0; n_own = '0; t_en = req_touch; t_way = fway;
        end
      end
      4'd4: begin
        if (!present) o_err = 1'b1;
        else begin o_grant = 1'b1; wr_en = 1'b1; n_vld = 1'b0; end
      end
      4'd5: begin
        o_way = vway;
        if (avail) o_err = 1'b1;
        else begin o_grant = 1'b1; o_addr = cur_tag; end
      end
      4'd6, 4'd7: begin
        if (!present) o_err = 1'b1;
        else begin
          o_grant = 1'b1; wr_en = 1'b1;
          n_lkv = (req_cmd == 4'd6); n_own = (req_cmd == 4'd6) ? req_ctx : '0;
        end
      end
      4'd8: begin
        if (!present) o_err = 1'b1;
        else o_grant = cur_lkv && (cur_own == req_ctx);
      end
      4'd9: begin
        o_hit = any; o_way = away;
        if (!any) o_err = 1'b1;
        else begin o_grant = 1'b1; wr_en = 1'b1; n_perm = req_perm; end
      end
      default: o_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          vld_q[s][w]  <= 1'b0;
          perm_q[s][w] <= P_NP;
          lkv_q[s][w]  <= 1'b0;
          own_q[s][w]  <= '0;
          rank_q[s][w] <= w[WAY_W-1:0];
        end
    end else if (req_valid) begin
      if (wr_en) begin
        tag_q[set_i][wsel]  <= n_tag;
        vld_q[set_i][wsel]  <= n_vld;
        perm_q[set_i][wsel] <= n_perm;
        lkv_q[set_i][wsel]  <= n_lkv;
        own_q[set_i][wsel]  <= n_own;
      end
      if (t_en)
        for (int w = 0; w < WAYS; w++) begin
          if (w == int'(t_way)) rank_q[set_i][w] <= '0;
          else if (rank_q[set_i][w] < rank_q[set_i][t_way])
            rank_q[set_i][w] <= rank_q[set_i][w] + 1'b1;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_way <= '0;
      resp_grant <= 1'b0; resp_addr <= '0; err <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_hit   <= req_valid && o_hit;
      resp_way   <= req_valid ? o_way : '0;
      resp_grant <= req_valid && o_grant;
      resp_addr  <= req_valid ? o_addr : '0;
      err        <= err || (req_valid && o_err);
    end
  end
endmodule

// File: rtl/tag_dir_chk.sv
module tag_dir_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_cmd,
  input logic       resp_valid,
  input logic       resp_hit,
  input logic       resp_grant,
  input logic       err
);
  p_resp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  p_no_spurious_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_grant_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd0) |=> (!resp_grant || resp_hit));
  p_alloc_ok_or_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd3) |=> (resp_grant || err));
  p_alloc_not_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd3) |=> !(resp_grant && resp_hit));
  p_lock_test_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd8) |=> (!resp_grant || resp_hit));
endmodule

bind tag_dir tag_dir_chk u_chk (.*);

// File: tb/tag_dir_bench.sv
module tag_dir_bench;
  localparam int ADDR_W = 32, IDX_LSB = 6, SETS = 8, WAYS = 4, CTX_W = 4;
  localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_touch = 0;
  logic [3:0] req_cmd = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [1:0] req_kind = 0, req_perm = 0;
  logic [CTX_W-1:0] req_ctx = 0;
  logic req_ready, resp_valid, resp_hit, resp_grant, err;
  logic [WAY_W-1:0] resp_way;
  logic [ADDR_W-1:0] resp_addr;

  always #10 clk = ~clk;

  tag_dir #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .SETS(SETS), .WAYS(WAYS), .CTX_W(CTX_W)) u_tag_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm), .req_ctx(req_ctx),
    .req_touch(req_touch), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_grant(resp_grant), .resp_addr(resp_addr), .err(err));

  int n_chk = 0, n_fail = 0;
  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  bit m_vld [SETS][WAYS];
  longint m_tag [SETS][WAYS];
  int m_perm [SETS][WAYS], m_own [SETS][WAYS];
  bit m_lkv [SETS][WAYS];
  int ord [SETS][$];
  bit e_valid, e_hit, e_grant, e_err;
  int e_way;
  longint e_addr;
  string e_tag = "R12";

  function automatic string tag_of(int c);
    case (c)
      0: return "R2"; 1: return "R4"; 2: return "R5"; 3: return "R6"; 4: return "R8";
      5: return "R9"; 6, 7, 8: return "R10"; 9: return "R11"; default: return "R7";
    endcase
  endfunction

  task automatic m_touch(int s, int w);
    for (int i = 0; i < ord[s].size(); i++)
      if (ord[s][i] == w) begin ord[s].delete(i); break; end
    ord[s].push_front(w);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ord[s].delete();
        for (int w = 0; w < WAYS; w++) begin
          m_vld[s][w] = 0; m_tag[s][w] = 0; m_perm[s][w] = 0; m_lkv[s][w] = 0; m_own[s][w] = 0;
          ord[s].push_back(w);
        end
      end
      e_valid = 0; e_hit = 0; e_way = 0; e_grant = 0; e_addr = 0; e_err = 0;
    end else begin
      e_valid = req_valid; e_hit = 0; e_way = 0; e_grant = 0; e_addr = 0;
      if (req_valid) begin
        int s, pw, aw, fw, vw, c;
        bit fail;
        s = int'((req_addr >> IDX_LSB) % SETS);
        c = int'(req_cmd);
        pw = -1; aw = -1; fw = -1; fail = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
          if (m_vld[s][w] && m_tag[s][w] == longint'(req_addr)) begin
            aw = w;
            if (m_perm[s][w] != 0) pw = w;
          end
          if (!m_vld[s][w] || m_perm[s][w] == 0) fw = w;
        end
        vw = ord[s][WAYS-1];
        e_tag = tag_of(c);
        e_hit = (pw >= 0); e_way = (pw >= 0) ? pw : 0;
        case (c)
          0: if (pw >= 0) begin
               e_grant = (m_perm[s][pw] == 3) || (m_perm[s][pw] == 2 && req_kind != 2);
               m_touch(s, pw);
             end
          1: begin e_hit = (aw >= 0); e_way = (aw >= 0) ? aw : 0; end
          2: e_grant = (aw >= 0) || (fw >= 0);
          3: begin
               e_way = (fw >= 0) ? fw : 0;
               if (pw >= 0 || fw < 0) fail = 1;
               else begin
                 e_grant = 1; m_vld[s][fw] = 1; m_tag[s][fw] = longint'(req_addr);
                 m_perm[s][fw] = 1; m_lkv[s][fw] = 0; m_own[s][fw] = 0;
                 if (req_touch) m_touch(s, fw);
               end
             end
          4: if (pw < 0) fail = 1; else begin e_grant = 1; m_vld[s][pw] = 0; end
          5: begin
               e_way = vw;
               if (aw >= 0 || fw >= 0) fail = 1;
               else begin e_grant = 1; e_addr = m_tag[s][vw]; end
             end
          6: if (pw < 0) fail = 1; else begin e_grant = 1; m_lkv[s][pw] = 1; m_own[s][pw] = int'(req_ctx); end
          7: if (pw < 0) fail = 1; else begin e_grant = 1; m_lkv[s][pw] = 0; m_own[s][pw] = 0; end
          8: if (pw < 0) fail = 1; else e_grant = m_lkv[s][pw] && m_own[s][pw] == int'(req_ctx);
          9: begin
               e_hit = (aw >= 0); e_way = (aw >= 0) ? aw : 0;
               if (aw < 0) fail = 1; else begin e_grant = 1; m_perm[s][aw] = int'(req_perm); end
             end
          default: fail = 1;
        endcase
        if (fail) e_err = 1;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    chk("R12", "resp_valid", resp_valid, e_valid);
    chk("R13", "err", err, e_err);
    if (rst_n && e_valid) begin
      chk(e_tag, "hit", resp_hit, e_hit);
      chk(e_tag, "way", resp_way, e_way);
      chk(e_tag, "grant", resp_grant, e_grant);
      chk(e_tag, "addr", resp_addr, e_addr);
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int s, int t);
    return ADDR_W'((longint'(t) << (IDX_LSB + SET_W)) | (longint'(s) << IDX_LSB));
  endfunction

  task automatic go(int c, logic [ADDR_W-1:0] a, int kind = 0, int perm = 0, int ctx = 0, bit touch = 0);
    req_valid = 1; req_cmd = 4'(c); req_addr = a; req_kind = 2'(kind);
    req_perm = 2'(perm); req_ctx = CTX_W'(ctx); req_touch = touch;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] A, B, C, D, E, F;
    int unsigned lcg;
    A = mk(1, 1); B = mk(1, 2); C = mk(1, 3); D = mk(1, 4); E = mk(1, 5); F = mk(1, 6);
    @(negedge clk);
    do_reset();
    chk("R12", "reset err", err, 0);
    chk("R12", "reset resp_valid", resp_valid, 0);

    go(3, A, 0, 0, 0, 1);
    chk("R6", "alloc grant", resp_grant, 1); chk("R6", "alloc way", resp_way, 0);
    chk("R12", "resp_valid after accept", resp_valid, 1);
    go(0, A, 0);
    chk("R2", "invalid line hit", resp_hit, 1); chk("R2", "invalid line grant", resp_grant, 0);
    go(9, A, 0, 2);
    chk("R11", "setperm grant", resp_grant, 1);
    go(0, A, 1); chk("R2", "RO fetch grant", resp_grant, 1);
    go(0, A, 2); chk("R2", "RO store grant", resp_grant, 0);
    go(9, A, 0, 3);
    go(0, A, 2); chk("R2", "RW store grant", resp_grant, 1);
    go(3, B, 0, 0, 0, 1); chk("R6", "second alloc way", resp_way, 1);
    go(3, C, 0, 0, 0, 1); chk("R1", "same set third way", resp_way, 2);
    go(3, D, 0, 0, 0, 0); chk("R1", "same set fourth way", resp_way, 3);
    go(2, E); chk("R5", "full set avail", resp_grant, 0);
    go(2, mk(2, 1)); chk("R1", "other set avail", resp_grant, 1);
    go(5, E); chk("R9", "victim untouched alloc", resp_addr, D); chk("R9", "victim way", resp_way, 3);
    go(0, D, 2); chk("R3", "store to invalid ungranted", resp_grant, 0);
    go(5, E); chk("R3", "hit moved to MRU", resp_addr, A);
    go(6, A, 0, 0, 5); chk("R10", "lock set", resp_grant, 1);
    go(8, A, 0, 0, 5); chk("R10", "lock test same", resp_grant, 1);
    go(8, A, 0, 0, 3); chk("R10", "lock test other", resp_grant, 0);
    go(7, A);
    go(8, A, 0, 0, 5); chk("R10", "lock cleared", resp_grant, 0);
    go(6, B, 0, 0, 7);
    go(9, B, 0, 0);
    go(0, B); chk("R2", "NotPresent access hit", resp_hit, 0);
    go(1, B); chk("R4", "raw lookup hit", resp_hit, 1); chk("R4", "raw lookup way", resp_way, 1);
    go(2, E); chk("R5", "NotPresent way is free", resp_grant, 1);
    go(3, E); chk("R6", "alloc into NotPresent way", resp_way, 1);
    go(8, E, 0, 0, 7); chk("R6", "alloc clears lock", resp_grant, 0);
    go(1, A);
    go(5, F); chk("R4", "raw lookup keeps recency", resp_addr, A);
    go(3, A); chk("R7", "double alloc err", err, 1);
    go(0, A); chk("R7", "state unchanged after error", resp_hit, 1);
    chk("R13", "err stays set", err, 1);
    do_reset();
    chk("R13", "err cleared by reset", err, 0);
    go(3, A); go(4, A); chk("R8", "dealloc grant", resp_grant, 1);
    go(0, A); chk("R8", "dealloc empties", resp_hit, 0);
    go(4, A); chk("R8", "dealloc absent err", err, 1);
    do_reset();
    go(5, A); chk("R9", "probe avail set grant", resp_grant, 0); chk("R9", "probe avail err", err, 1);
    do_reset();
    go(8, A); chk("R10", "lock test absent err", err, 1);
    do_reset();
    go(9, A); chk("R11", "setperm absent err", err, 1);
    do_reset();
    go(15, A); chk("R7", "undefined cmd err", err, 1);
    do_reset();

    lcg = 32'h1234_5678;
    for (int i = 0; i < 6000; i++) begin
      int c;
      if (i % 300 == 299) do_reset();
      lcg = lcg * 1664525 + 1013904223;
      c = int'(lcg[27:24]);
      if (c > 9 && lcg[20:18] != 0) c = c - 8;
      if (lcg[31]) begin
        req_valid = 1; req_cmd = 4'(c);
        req_addr = mk(int'(lcg[8]), int'(lcg[11:9]) % 6);
        req_kind = 2'(int'(lcg[14:13]) % 3); req_perm = lcg[16:15];
        req_ctx = CTX_W'(lcg[3:2]); req_touch = lcg[5];
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule